// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns single host requests into clause-22 management transactions on a two-wire MDC/MDIO link. A request is a read or a write to one register of one PHY: a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block derives MDC from the system clock with a fixed divider. It shifts the frame out on MDIO, releases the line through an output enable at the turnaround, and for reads collects the PHY's reply. Completion is a one-cycle `done` pulse. For a read, `rd_data` carries the register contents in that same cycle.

A level input chooses, at the moment a request is taken, whether a run of 32 one-bits goes out ahead of the frame. Software can therefore drop the preamble once it knows the PHY tolerates this. The read reply is taken as a fixed window of 19 sampled bits: the two turnaround bits, 16 data bits and one trailing idle bit. Only the 16 data bits are kept. While a transaction runs, the block ignores further requests.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are all 0.
- R2: While busy, MDC has a period of CLK_DIV system clocks. In each period it is low for the first CLK_DIV/2 clocks and high for the rest. The default of 20 gives 2.5 MHz from a 50 MHz clock. MDC stays low while idle.
- R3: When `pre_en` is 1 at request accept, MDIO is driven to 1 for the first 32 MDC periods (PRE_LEN). When it is 0, the frame's first bit goes out in the first period.
- R4: A read sends 16 driven bits, MSB first: 1, 1, then 0, 1, then 1, 0, then the PHY address bits 4..0, then the register address bits 4..0.
- R5: A write sends 32 driven bits, MSB first: 0, 1, then 0, 1, then the PHY address bits 4..0, the register address bits 4..0, then 1, 0, then the data bits 15..0.
- R6: After a read's 16 driven bits, `mdio_oe` is 0 for 19 MDC periods. MDIO is sampled at each of these 19 rising edges. `rd_data` is set to samples 3 through 18, with the third sample as bit 15. Samples 1, 2 and 19 are discarded. `done` pulses as the 19th period ends.
- R7: After a write's 32 driven bits, `mdio_oe` is 0 for 2 MDC periods (WR_TAIL). Then `done` pulses.
- R8: MDIO output and output enable change only at an MDC falling edge or while MDC is low, never while MDC is high. The PHY sees each bit at an MDC rising edge. While released, `mdio_o` is 0.
- R9: `busy` is 1 from the cycle after accept until the cycle in which `done` is 1. `done` is a single-cycle pulse in which `busy` is already 0. A request presented while busy is ignored: it changes no transmitted bit and starts no later frame.
- R10: `rd_data` changes only in a read's `done` cycle. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| pre_en | input | 1 | Send the 32-bit preamble before this frame |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench targets the read window's edges with a PHY model that drives turnaround and idle bits unlike the data edge bits. A design that keeps the wrong 16 of the 19 samples returns a shifted word. A design with an off-by-one release count shows the wrong number of MDC rising edges before `done`. The bench also toggles `pre_en`, since hardwiring the preamble either way changes the bit stream. It also presents a conflicting request in mid-frame: a design that accepts it corrupts the frame or starts a second one. Write-then-read sequences catch a design that lets a write disturb `rd_data`.

// File: rtl/mdio_fm_pkg.sv
package mdio_fm_pkg;

   localparam int PHY_AW     = 5;
   localparam int REG_AW     = 5;
   localparam int DATA_W     = 16;
   localparam int HDR_BITS   = 16;
   localparam int FRAME_BITS = 32;
   localparam int READ_WIN   = 19;

   localparam logic [1:0] SYNC_PAD = 2'b11;
   localparam logic [1:0] SOF      = 2'b01;
   localparam logic [1:0] OPC_RD   = 2'b10;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] TA_WR    = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_SEND,
      ST_LISTEN
   } seq_state_e;

   // Left-aligned frame image: reads use only the upper HDR_BITS.
   function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic              wr,
      input logic [PHY_AW-1:0] phy,
      input logic [REG_AW-1:0] rga,
      input logic [DATA_W-1:0] wd);
      if (wr)
         build_frame = {SOF, OPC_WR, phy, rga, TA_WR, wd};
      else
         build_frame = {SYNC_PAD, SOF, OPC_RD, phy, rga, {DATA_W{1'b0}}};
   endfunction

endpackage

// File: rtl/mdio_fm_mdc.sv
module mdio_fm_mdc #(
   parameter int CLK_DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);

   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = $clog2(CLK_DIV);

   logic [CW-1:0] cnt;

   assign rise_tick = run && (cnt == CW'(HALF - 1));
   assign fall_tick = run && (cnt == CW'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (fall_tick) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
         if (rise_tick)
            mdc <= 1'b1;
      end
   end

   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mdc); // R2
   AST_MDC_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> (cnt >= CW'(HALF))); // R2
   AST_MDC_ROSE_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> (cnt == CW'(HALF))); // R2

endmodule

// File: rtl/mdio_fm_cap.sv
module mdio_fm_cap #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              din,
   output logic [DATA_W-1:0] word
);

   // Only the newest DATA_W+1 samples matter: data plus the trailing idle bit.
   logic [DATA_W:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh <= '0;
      else if (clear)
         sh <= '0;
      else if (sample)
         sh <= {sh[DATA_W-1:0], din};
   end

   assign word = sh[DATA_W:1];

   AST_CAP_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !clear) |=> (sh[0] == $past(din))); // R6

endmodule

// File: rtl/mdio_fm_seq.sv
module mdio_fm_seq
   import mdio_fm_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int WR_TAIL = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [PHY_AW-1:0] req_phy,
   input  logic [REG_AW-1:0] req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              pre_en,
   input  logic              fall_tick,
   output logic              accept,
   output logic              busy,
   output logic              drive_en,
   output logic              drive_bit,
   output logic              listen,
   output logic              rd_commit,
   output logic              done
);

   localparam int M1        = (PRE_LEN > FRAME_BITS) ? PRE_LEN : FRAME_BITS;
   localparam int M2        = (READ_WIN > WR_TAIL) ? READ_WIN : WR_TAIL;
   localparam int MAX_SLOTS = (M1 > M2) ? M1 : M2;
   localparam int CNT_W     = $clog2(MAX_SLOTS + 1);

   localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
   localparam logic [CNT_W-1:0] RHDR_LAST = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0] WFRM_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] RWIN_LAST = CNT_W'(READ_WIN - 1);
   localparam logic [CNT_W-1:0] WTL_LAST  = CNT_W'(WR_TAIL - 1);

   seq_state_e             state;
   logic [CNT_W-1:0]       slot_left;
   logic [FRAME_BITS-1:0]  shreg;
   logic                   wr_q;
   logic                   last_slot;

   assign accept    = req_valid && (state == ST_IDLE);
   assign busy      = (state != ST_IDLE);
   assign last_slot = (slot_left == '0);
   assign drive_en  = (state == ST_PRE) || (state == ST_SEND);
   assign drive_bit = (state == ST_PRE) ? 1'b1 :
                      (state == ST_SEND) ? shreg[FRAME_BITS-1] : 1'b0;
   assign listen    = (state == ST_LISTEN) && !wr_q;
   assign rd_commit = listen && fall_tick && last_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         slot_left <= '0;
         shreg     <= '0;
         wr_q      <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  wr_q  <= req_write;
                  shreg <= build_frame(req_write, req_phy, req_reg, req_wdata);
                  if (pre_en) begin
                     state     <= ST_PRE;
                     slot_left <= PRE_LAST;
                  end else begin
                     state     <= ST_SEND;
                     slot_left <= req_write ? WFRM_LAST : RHDR_LAST;
                  end
               end
            end
            ST_PRE: begin
               if (fall_tick) begin
                  if (last_slot) begin
                     state     <= ST_SEND;
                     slot_left <= wr_q ? WFRM_LAST : RHDR_LAST;
                  end else begin
                     slot_left <= slot_left - 1'b1;
                  end
               end
            end
            ST_SEND: begin
               if (fall_tick) begin
                  if (last_slot) begin
                     state     <= ST_LISTEN;
                     slot_left <= wr_q ? WTL_LAST : RWIN_LAST;
                  end else begin
                     slot_left <= slot_left - 1'b1;
                     shreg     <= {shreg[FRAME_BITS-2:0], 1'b0};
                  end
               end
            end
            ST_LISTEN: begin
               if (fall_tick) begin
                  if (last_slot) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     slot_left <= slot_left - 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_BUSY_HOLDS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wr_q)); // R9
   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy); // R9

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mdio_fm_pkg::*;
#(
   parameter int CLK_DIV = 20,
   parameter int PRE_LEN = 32,
   parameter int WR_TAIL = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   input  logic        pre_en,
   output logic        busy,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 4");
      end
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
      if (WR_TAIL < 1) begin : g_bad_tail
         $error("WR_TAIL must be at least 1");
      end
   endgenerate

   logic              rise_tick;
   logic              fall_tick;
   logic              accept;
   logic              listen;
   logic              rd_commit;
   logic [DATA_W-1:0] cap_word;

   mdio_fm_seq #(
      .PRE_LEN (PRE_LEN),
      .WR_TAIL (WR_TAIL)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_phy   (req_phy),
      .req_reg   (req_reg),
      .req_wdata (req_wdata),
      .pre_en    (pre_en),
      .fall_tick (fall_tick),
      .accept    (accept),
      .busy      (busy),
      .drive_en  (mdio_oe),
      .drive_bit (mdio_o),
      .listen    (listen),
      .rd_commit (rd_commit),
      .done      (done)
   );

   mdio_fm_mdc #(
      .CLK_DIV (CLK_DIV)
   ) u_mdc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_fm_cap #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .sample (rise_tick && listen),
      .din    (mdio_i),
      .word   (cap_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_commit)
         rd_data <= cap_word;
   end

   AST_LINE_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe); // R1
   AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !mdio_oe |-> !mdio_o); // R8
   AST_RDATA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> done); // R10

endmodule

// File: tb/sim_mdio_frame_master.sv
`timescale 1ns/1ps
module sim_mdio_frame_master;

   localparam int CLK_PERIOD = 20;
   localparam int DIV        = 20;
   localparam int PRE        = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [4:0]  req_phy = '0;
   logic [4:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        pre_en = 1'b0;
   logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
   logic [15:0] rd_data;

   mdio_frame_master #(.CLK_DIV(DIV), .PRE_LEN(PRE), .WR_TAIL(2)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .pre_en(pre_en), .busy(busy), .done(done), .rd_data(rd_data),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc = 0;
   bit wd_hit = 0;

   // PHY model state
   logic        t_wr = 1'b0;
   logic        t_pre = 1'b0;
   logic [15:0] t_phy_data = '0;
   int          rcount = 0;
   logic [1:0]  slog [0:127];
   int          last_rise = 0;
   int          per_err = 0, duty_err = 0, hi_change_err = 0;
   logic        prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !wd_hit) begin
         wd_hit = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R9: actual %0d expected below %0d cycles", cyc, 150000);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   always @(posedge mdc) begin
      if (rcount < 128) slog[rcount] = {mdio_oe, mdio_o};
      if (rcount > 0 && (cyc - last_rise) != DIV) per_err++;
      last_rise = cyc;
      rcount++;
   end

   always @(negedge mdc) begin
      if ((cyc - last_rise) != DIV/2) duty_err++;
   end

   always @(negedge clk) begin
      if (rst_n && mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe))
         hi_change_err++;
      prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
   end

   // PHY reply: turnaround high-Z (pulled to 1), then 0, 16 data bits, idle 1
   always_comb begin
      int j;
      j = rcount - ((t_pre ? PRE : 0) + 16);
      if (!t_wr && j == 1)                mdio_i = 1'b0;
      else if (!t_wr && j >= 2 && j <= 17) mdio_i = t_phy_data[17 - j];
      else                                 mdio_i = 1'b1;
   end

   function automatic logic [1:0] exp_slot(input int i, input bit wr, input bit pre,
                                            input logic [4:0] phy, input logic [4:0] rg,
                                            input logic [15:0] wd);
      int p;
      logic [31:0] fr;
      int n;
      p  = pre ? PRE : 0;
      if (i < p) return 2'b11;
      fr = wr ? {2'b01, 2'b01, phy, rg, 2'b10, wd} : {2'b11, 2'b01, 2'b10, phy, rg, 16'h0};
      n  = wr ? 32 : 16;
      if (i - p < n) return {1'b1, fr[31 - (i - p)]};
      return 2'b00;
   endfunction

   task automatic do_txn(input bit wr, input bit pre, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd,
                         input logic [15:0] phydata, input bit inject);
      logic [15:0] prev_rd;
      int guard, total, p, n, e_pre, e_hdr, e_rel, busy_drop;
      prev_rd = rd_data;
      t_wr = wr; t_pre = pre; t_phy_data = phydata; rcount = 0;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd; pre_en = pre;
      @(negedge clk);
      req_valid = 0; req_phy = 5'($urandom); req_reg = 5'($urandom);
      req_wdata = 16'($urandom); req_write = 1'($urandom);
      check(busy == 1'b1, "R9", "busy after accept", busy, 1);
      busy_drop = 0;
      if (inject) begin
         repeat (7*DIV) @(negedge clk);
         req_valid = 1; req_write = !wr; req_phy = ~phy; req_reg = ~rg;
         req_wdata = ~wd; pre_en = !pre;
         repeat (3) @(negedge clk);
         req_valid = 0;
      end
      guard = 0;
      while (!done && guard < 5000) begin
         if (!busy) busy_drop++;
         @(negedge clk);
         guard++;
      end
      check(done == 1'b1, "R9", "done seen", done, 1);
      check(busy == 1'b0 && busy_drop == 0, "R9", "busy until done", busy_drop, 0);
      p = pre ? PRE : 0;
      n = wr ? 32 : 16;
      total = p + n + (wr ? 2 : 19);
      check(rcount == total, wr ? "R7" : "R6", "MDC rising edges per frame", rcount, total);
      e_pre = 0; e_hdr = 0; e_rel = 0;
      for (int i = 0; i < total && i < 128; i++) begin
         if (slog[i] !== exp_slot(i, wr, pre, phy, rg, wd)) begin
            if (i < p) e_pre++;
            else if (i < p + n) e_hdr++;
            else e_rel++;
         end
      end
      check(e_pre == 0, "R3", "preamble slots wrong", e_pre, 0);
      check(e_hdr == 0, wr ? "R5" : "R4", "frame bits wrong", e_hdr, 0);
      check(e_rel == 0, wr ? "R7" : "R6", "released slots wrong", e_rel, 0);
      if (!wr) check(rd_data == phydata, "R6", "read data", rd_data, phydata);
      else     check(rd_data == prev_rd, "R10", "read data kept over write", rd_data, prev_rd);
      @(negedge clk);
      check(done == 1'b0, "R9", "done single cycle", done, 0);
      if (inject) begin
         repeat (3*DIV) @(negedge clk);
         check(busy == 1'b0 && rcount == total, "R9", "busy request ignored", rcount, total);
      end
   endtask

   initial begin
      void'($urandom(32'd20240817));
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1", "reset state",
            {busy, done, mdc, mdio_oe}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      check(busy == 0 && mdc == 0 && mdio_oe == 0, "R1", "idle after reset",
            {busy, mdc, mdio_oe}, 0);

      // directed corners
      do_txn(0, 1, 5'd1,  5'd1,  16'h0000, 16'hA5C3, 0);   // R4 R6 with preamble
      do_txn(0, 0, 5'd31, 5'd0,  16'h0000, 16'h8001, 0);   // R3 no preamble, edge data bits
      do_txn(1, 1, 5'd0,  5'd31, 16'hFFFF, 16'h0000, 0);   // R5 R10
      do_txn(1, 0, 5'd21, 5'd10, 16'h0000, 16'hFFFF, 0);   // R7 R10
      do_txn(0, 0, 5'd10, 5'd21, 16'h0000, 16'hFFFF, 0);   // R6 all ones
      do_txn(0, 1, 5'd3,  5'd7,  16'h0000, 16'h0000, 1);   // R9 ignore while busy
      do_txn(1, 0, 5'd17, 5'd2,  16'h1234, 16'h0000, 1);   // R9 ignore while busy

      // constrained random
      for (int k = 0; k < 12; k++) begin
         do_txn(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
                16'($urandom), 16'($urandom), 0);
      end

      check(per_err == 0, "R2", "MDC period mismatches", per_err, 0);
      check(duty_err == 0, "R2", "MDC high time mismatches", duty_err, 0);
      check(hi_change_err == 0, "R8", "MDIO changed while MDC high", hi_change_err, 0);
      check(mdc == 0 && busy == 0, "R2", "MDC low when idle", mdc, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule